// File: doc/BRIEF.md
# Iterative Integer Divider with Data-Dependent Latency

This block performs 32-bit integer division and remainder for the four standard RISC-V M-extension divide operations: signed and unsigned quotient, and signed and unsigned remainder. A request carries a 2-bit operation code, a dividend and a divisor. It enters through a valid/ready handshake. The block retires one quotient bit per clock cycle with a restoring shift-subtract step, working on operand magnitudes. It corrects the signs when it presents the result.

The block skips the leading zero bits of the dividend magnitude before it starts iterating. The number of iteration cycles is therefore the bit length of that magnitude. Division by zero and the signed overflow case do not iterate at all; they finish on the shortest path. Once a request has been accepted, it always runs to completion, because the block has no cancel input.

The response leaves through a second valid/ready handshake. Back-pressure works as follows. The result stays valid and unchanged for as long as `rsp_ready` is low. No new request is accepted until the held result has been taken. `busy` is a plain status pin that is high while an operation is being computed.

Top module: `serial_int_div`

## Requirements
- R1: The operation code `req_op` uses bit 0 for unsigned when it is 1 and bit 1 for remainder when it is 1 (00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder). The unsigned operations return floor(a/b) and a mod b.
- R2: The signed quotient is truncated toward zero. It is negative exactly when the operand signs differ and the result is nonzero.
- R3: The signed remainder takes the sign of the dividend and satisfies a = q*b + r.
- R4: When the divisor is zero, every operation returns all ones as the quotient and the unmodified dividend as the remainder, with a latency of 2.
- R5: For a signed operation with dividend 0x80000000 and divisor 0xFFFFFFFF, the quotient is 0x80000000 and the remainder is 0, with a latency of 2.
- R6: Latency is counted from the cycle of the request handshake to the first cycle with `rsp_valid` high. Outside R4 and R5, it is 1 + max(1, bit length of the dividend magnitude), which gives a range of 2 to 33.
- R7: `req_ready` is high only when the block holds no operation. A request offered while the block is busy or holding a result is not accepted and has no effect on the result returned.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays stable. The result is released on the cycle `rsp_ready` is high.
- R9: An accepted operation cannot be abandoned. `busy` rises in the cycle after acceptance and stays high until `rsp_valid` rises.
- R10: Reset, asserted at any time, returns the block to idle with `req_ready` high and both `rsp_valid` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code: bit 0 unsigned, bit 1 remainder |
| req_dividend | input | 32 | Dividend |
| req_divisor | input | 32 | Divisor |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 32 | Quotient or remainder, sign corrected |
| busy | output | 1 | Operation being computed |

## Verification
The hardest situations to reach from the ports are two. The first is a request that arrives while the block is still busy, or while it is holding an unconsumed result. The second is the point where a long computation ends at the same moment the consumer is stalling. The bench starts a 10-bit dividend and keeps offering a different request during the iterations. It then withholds `rsp_ready` for several cycles and checks that the first result comes out intact. It also reaches the 33-cycle path with full-width dividends, including the most-negative dividend and a signed dividend whose magnitude is itself 0x80000000. A reset issued part-way through an iteration checks that the block returns to idle.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SPEC = 2'd1,
    ST_ITER = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;

  localparam int OP_UNS_BIT = 0;
  localparam int OP_REM_BIT = 1;
endpackage

// File: rtl/div_bitlen.sv
module div_bitlen #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] bitlen
);
  always_comb begin
    bitlen = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) bitlen = CW'(i + 1);
    end
  end
endmodule

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [1:0]    op,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic [W-1:0]  mag_a,
  output logic [W-1:0]  mag_b,
  output logic          neg_quo,
  output logic          neg_rem,
  output logic          special,
  output logic [W-1:0]  spec_quo,
  output logic [W-1:0]  spec_rem,
  output logic [CW-1:0] iters
);
  import div_pkg::*;

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic          is_signed, a_neg, b_neg, by_zero, ovf;
  logic [CW-1:0] len_a;

  assign is_signed = ~op[OP_UNS_BIT];
  assign a_neg     = is_signed & dividend[W-1];
  assign b_neg     = is_signed & divisor[W-1];
  assign mag_a     = a_neg ? (~dividend + 1'b1) : dividend;
  assign mag_b     = b_neg ? (~divisor + 1'b1) : divisor;
  assign neg_quo   = a_neg ^ b_neg;
  assign neg_rem   = a_neg;

  assign by_zero   = (divisor == '0);
  assign ovf       = is_signed && (dividend == MOST_NEG) && (divisor == '1);
  assign special   = by_zero | ovf;
  assign spec_quo  = by_zero ? '1 : dividend;
  assign spec_rem  = by_zero ? dividend : '0;

  div_bitlen #(.W(W)) u_len (
    .val    (mag_a),
    .bitlen (len_a)
  );

  assign iters = (len_a == '0) ? CW'(1) : len_a;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         fits;

  assign trial   = {rem_in, quo_in[W-1]};
  assign fits    = (trial >= {1'b0, divisor});
  assign diff    = trial[W-1:0] - divisor;
  assign rem_out = fits ? diff : trial[W-1:0];
  assign quo_out = {quo_in[W-2:0], fits};
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         pick_rem,
  output logic [W-1:0] result
);
  logic [W-1:0] sel;
  logic         flip;

  assign sel    = pick_rem ? rem : quo;
  assign flip   = pick_rem ? neg_rem : neg_quo;
  assign result = flip ? (~sel + 1'b1) : sel;
endmodule

// File: rtl/serial_int_div.sv
module serial_int_div #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [XLEN-1:0] req_dividend,
  input  logic [XLEN-1:0] req_divisor,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_data,
  output logic            busy
);
  import div_pkg::*;

  localparam int CW = $clog2(XLEN + 1);
  localparam logic [CW:0] RUN_MAX = XLEN[CW:0];

  div_state_e      state_q;
  logic [XLEN-1:0] quo_q, rem_q, dvsr_q;
  logic            negq_q, negr_q, pick_rem_q;
  logic [CW-1:0]   cnt_q;

  logic [XLEN-1:0] mag_a, mag_b, spec_quo, spec_rem;
  logic            neg_quo, neg_rem, special;
  logic [CW-1:0]   iters, shamt;
  logic [XLEN-1:0] step_rem, step_quo;
  logic            accept;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign busy      = (state_q == ST_SPEC) || (state_q == ST_ITER);
  assign accept    = req_valid && req_ready;
  assign shamt     = CW'(XLEN) - iters;

  div_operand_prep #(.W(XLEN)) u_prep (
    .op       (req_op),
    .dividend (req_dividend),
    .divisor  (req_divisor),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .neg_quo  (neg_quo),
    .neg_rem  (neg_rem),
    .special  (special),
    .spec_quo (spec_quo),
    .spec_rem (spec_rem),
    .iters    (iters)
  );

  div_step #(.W(XLEN)) u_step (
    .rem_in  (rem_q),
    .quo_in  (quo_q),
    .divisor (dvsr_q),
    .rem_out (step_rem),
    .quo_out (step_quo)
  );

  div_result_fix #(.W(XLEN)) u_fix (
    .quo      (quo_q),
    .rem      (rem_q),
    .neg_quo  (negq_q),
    .neg_rem  (negr_q),
    .pick_rem (pick_rem_q),
    .result   (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      quo_q      <= '0;
      rem_q      <= '0;
      dvsr_q     <= '0;
      negq_q     <= 1'b0;
      negr_q     <= 1'b0;
      pick_rem_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pick_rem_q <= req_op[OP_REM_BIT];
            if (special) begin
              quo_q   <= spec_quo;
              rem_q   <= spec_rem;
              negq_q  <= 1'b0;
              negr_q  <= 1'b0;
              state_q <= ST_SPEC;
            end else begin
              quo_q   <= mag_a << shamt;
              rem_q   <= '0;
              dvsr_q  <= mag_b;
              negq_q  <= neg_quo;
              negr_q  <= neg_rem;
              cnt_q   <= iters;
              state_q <= ST_ITER;
            end
          end
        end
        ST_SPEC: state_q <= ST_DONE;
        ST_ITER: begin
          quo_q <= step_quo;
          rem_q <= step_rem;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker state: length of the current busy run.
  logic [CW:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy); // R9
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || rsp_valid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R8
  AST_LATENCY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < RUN_MAX); // R6
  AST_PARTIAL_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ITER) |-> rem_q < dvsr_q); // R1
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy && !rsp_valid); // R7
endmodule

// File: tb/serial_int_div_tb.sv
module serial_int_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_dividend = '0;
  logic [31:0] req_divisor = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  serial_int_div #(.XLEN(32)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_dividend (req_dividend),
    .req_divisor  (req_divisor),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .busy         (busy)
  );

  // {op, dividend, divisor, expected}
  localparam int NV = 27;
  localparam logic [97:0] VEC [0:NV-1] = '{
    {2'b01, 32'd100,       32'd7,         32'd14},
    {2'b11, 32'd100,       32'd7,         32'd2},
    {2'b00, 32'hFFFFFF9C,  32'd7,         32'hFFFFFFF2},
    {2'b10, 32'hFFFFFF9C,  32'd7,         32'hFFFFFFFE},
    {2'b00, 32'd100,       32'hFFFFFFF9,  32'hFFFFFFF2},
    {2'b10, 32'd100,       32'hFFFFFFF9,  32'd2},
    {2'b00, 32'hFFFFFF9C,  32'hFFFFFFF9,  32'd14},
    {2'b10, 32'hFFFFFF9C,  32'hFFFFFFF9,  32'hFFFFFFFE},
    {2'b01, 32'hFFFFFFFF,  32'd1,         32'hFFFFFFFF},
    {2'b01, 32'h80000000,  32'd3,         32'h2AAAAAAA},
    {2'b11, 32'h80000000,  32'd3,         32'd2},
    {2'b00, 32'd5,         32'd0,         32'hFFFFFFFF},
    {2'b10, 32'hFFFFFFFB,  32'd0,         32'hFFFFFFFB},
    {2'b01, 32'd0,         32'd0,         32'hFFFFFFFF},
    {2'b11, 32'h00001234,  32'd0,         32'h00001234},
    {2'b00, 32'h80000000,  32'hFFFFFFFF,  32'h80000000},
    {2'b10, 32'h80000000,  32'hFFFFFFFF,  32'd0},
    {2'b01, 32'h80000000,  32'hFFFFFFFF,  32'd0},
    {2'b11, 32'h80000000,  32'hFFFFFFFF,  32'h80000000},
    {2'b00, 32'd0,         32'd5,         32'd0},
    {2'b01, 32'd1,         32'd1,         32'd1},
    {2'b11, 32'd3,         32'd5,         32'd3},
    {2'b00, 32'h80000000,  32'd2,         32'hC0000000},
    {2'b01, 32'hDEADBEEF,  32'h10,        32'h0DEADBEE},
    {2'b11, 32'hDEADBEEF,  32'h10,        32'h0000000F},
    {2'b01, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'd1},
    {2'b10, 32'hFFFFFFF9,  32'd7,         32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [1:0] op, input logic [31:0] a,
                                     input logic [31:0] b);
    logic [31:0] m;
    int len;
    if (b == 32'd0) return 2;                                        // R4
    if (!op[0] && a == 32'h80000000 && b == 32'hFFFFFFFF) return 2;  // R5
    m = (!op[0] && a[31]) ? (~a + 32'd1) : a;
    len = 0;
    for (int i = 0; i < 32; i++) if (m[i]) len = i + 1;
    return 1 + ((len < 1) ? 1 : len);                                // R6
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic [31:0] a,
                                   input logic [31:0] b);
    if (b == 32'd0) return "R4";
    if (!op[0] && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R5";
    if (op[0]) return "R1";
    return op[1] ? "R3" : "R2";
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] data, output int lat, output int gaps);
    @(negedge clk);
    req_op = op; req_dividend = a; req_divisor = b; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 1; gaps = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (!busy) gaps++;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    data = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat, gaps;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 req_ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R10 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R10 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b, e;
      {op, a, b, e} = VEC[i];
      run_op(op, a, b, d, lat, gaps);
      chk(tag_of(op, a, b), d, e);
      chk("R6 latency", 32'(lat), 32'(exp_latency(op, a, b)));
      chk("R9 busy until result", 32'(gaps), 32'd0);
    end

    // R7: requests offered while busy or holding are ignored; R8: back-pressure
    @(negedge clk);
    req_op = 2'b01; req_dividend = 32'd1000; req_divisor = 32'd3; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_op = 2'b11; req_dividend = 32'd7; req_divisor = 32'd2;
    for (int k = 0; k < 4; k++) begin
      chk("R7 ready low while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk("R8 valid held", {31'd0, rsp_valid}, 32'd1);
      chk("R8 data held", rsp_data, 32'd333);
      chk("R7 ready low while holding", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R7 first request result", rsp_data, 32'd333);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 released", {31'd0, rsp_valid}, 32'd0);
    chk("R8 ready after release", {31'd0, req_ready}, 32'd1);

    // R10: reset in the middle of an iteration
    @(negedge clk);
    req_op = 2'b01; req_dividend = 32'hFFFF0000; req_divisor = 32'd9; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 busy mid-run", {31'd0, busy}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 idle after mid-run reset", {30'd0, busy, rsp_valid}, 32'd0);
    chk("R10 ready after mid-run reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    run_op(2'b00, 32'hFFFFFF9C, 32'd7, d, lat, gaps);
    chk("R2 after reset", d, 32'hFFFFFFF2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule